// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block produces the four gate-drive timing signals for a full-bridge power stage that runs at a fixed switching frequency. Each bridge leg gets a complementary pair of outputs. Each output is nominally high for half of the switching period. Power is not set by pulse width. It is set by how far the second leg's pair lags the first leg's pair, anywhere from no lag (0 degrees) to half a period (180 degrees).

An oscillator tick marks the start of every switching period. On that tick the block samples a digital phase command and two dead-time settings, one for each leg. The first leg toggles in step with the tick. The second leg toggles at the same points, offset by the clamped phase count and wrapped around the period. Before any output of a pair can rise, its partner must already be off, and the block then waits a programmable number of clock cycles. This wait is always applied and has a minimum length of one cycle. A disable input from the fault or supply-monitor logic pulls all four outputs low at once.

Top module: `psb_bridge`

## Requirements
- R1: After reset, and until the first `periodTick` is sampled, all four outputs are low.
- R2: The internal period position restarts at 0 in the cycle after a sampled tick and counts 0 to PERIOD-1, wrapping. The first-leg raw state is high for positions 0 to PERIOD/2-1 and low for the rest. `outA` follows the raw high state and `outB` follows the raw low state.
- R3: `outA` and `outB` are never high together, and `outC` and `outD` are never high together.
- R4: If the phase command exceeds ZERO_TH, the phase count is `phaseCmd - ZERO_TH`. The second-leg raw state is high when `(position - phase) mod PERIOD` is below PERIOD/2. `outC` follows the raw high state and `outD` follows the raw low state.
- R5: A phase command at or below ZERO_TH gives a phase count of exactly 0, so the second leg switches together with the first.
- R6: A phase command at or above ZERO_TH + PERIOD/2 saturates at a phase count of PERIOD/2 (180 degrees). At that setting `outC` is the dead-timed image of the first leg's raw low state.
- R7: Outputs A and B use the first-leg dead-time setting. Outputs C and D use the second-leg setting. The two settings are independent of each other.
- R8: An output rises only after its raw state has been high for a number of cycles equal to its leg's effective dead time. A dead-time setting of 0 is treated as 1.
- R9: A dead-time setting above PERIOD/2-1 is clamped to PERIOD/2-1, so every output still produces at least a one-cycle pulse in each period.
- R10: While `outDisable` is high, all four outputs are low in the same cycle. After release, each output again waits its full dead time before rising.
- R11: The phase command and both dead-time settings are sampled only on a tick. A change between ticks has no effect on the outputs until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodTick | input | 1 | One-cycle pulse marking the start of a switching period |
| phaseCmd | input | CMD_W | Phase command, offset by ZERO_TH and clamped to PERIOD/2 |
| deadAbSet | input | DEAD_W | Dead-time setting in clock cycles for outputs A and B |
| deadCdSet | input | DEAD_W | Dead-time setting in clock cycles for outputs C and D |
| outDisable | input | 1 | Forces all outputs low while high |
| outA | output | 1 | First leg, high half |
| outB | output | 1 | First leg, low half |
| outC | output | 1 | Second leg, high half (phase shifted) |
| outD | output | 1 | Second leg, low half (phase shifted) |

## Verification
The hardest case to reach from the ports is a disable pulse that lands in the middle of an output's high window and is released while that output's raw state is still high. Only that case shows whether the dead-time count restarts or whether the output jumps straight back high. The stimulus places the pulse a few cycles into the first-leg high window with a long dead time, so the release falls inside the same window. A second hard case is a settings change between ticks. The bench changes the command and both dead times in the middle of a period and compares, cycle by cycle, against a reference model that only picks up the new values at the next tick.

// File: rtl/psb_pkg.sv
package psb_pkg;
  // Strobes from the period timing control to the dead-time datapath.
  typedef struct packed {
    logic live;   // a tick has been seen, legs are switching
    logic legAb;  // first leg raw high phase
    logic legCd;  // second leg raw high phase
  } psbStrobe_t;
endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
  import psb_pkg::*;
#(
  parameter int PERIOD  = 20,
  parameter int CMD_W   = 8,
  parameter int ZERO_TH = 4,
  parameter int DEAD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodTick,
  input  logic [CMD_W-1:0]  phaseCmd,
  input  logic [DEAD_W-1:0] deadAbSet,
  input  logic [DEAD_W-1:0] deadCdSet,
  output psbStrobe_t        strobe,
  output logic [DEAD_W-1:0] deadAb,
  output logic [DEAD_W-1:0] deadCd
);
  localparam int HALF  = PERIOD / 2;
  localparam int CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic [CNT_W-1:0]  phaseQ;
  logic [CNT_W-1:0]  phaseNext;
  logic [CMD_W:0]    cmdDiff;
  logic [CNT_W:0]    shifted;

  function automatic logic [DEAD_W-1:0] clampDead(input logic [DEAD_W-1:0] v);
    if (v == '0) return DEAD_W'(1);
    if (v > DEAD_W'(HALF - 1)) return DEAD_W'(HALF - 1);
    return v;
  endfunction

  // Phase command: at or below threshold is zero shift, saturate at half period.
  always_comb begin
    cmdDiff = {1'b0, phaseCmd} - (CMD_W+1)'(ZERO_TH);
    if (phaseCmd <= CMD_W'(ZERO_TH))
      phaseNext = '0;
    else if (cmdDiff >= (CMD_W+1)'(HALF))
      phaseNext = CNT_W'(HALF);
    else
      phaseNext = CNT_W'(cmdDiff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      run    <= 1'b0;
      phaseQ <= '0;
      deadAb <= DEAD_W'(1);
      deadCd <= DEAD_W'(1);
    end else if (periodTick) begin
      cnt    <= '0;
      run    <= 1'b1;
      phaseQ <= phaseNext;
      deadAb <= clampDead(deadAbSet);
      deadCd <= clampDead(deadCdSet);
    end else if (run) begin
      cnt <= (cnt == CNT_W'(PERIOD - 1)) ? '0 : cnt + 1'b1;
    end
  end

  // Second leg position: (cnt - phase) modulo PERIOD.
  always_comb begin
    shifted = {1'b0, cnt} + (CNT_W+1)'(PERIOD) - {1'b0, phaseQ};
    if (shifted >= (CNT_W+1)'(PERIOD))
      shifted = shifted - (CNT_W+1)'(PERIOD);
  end

  assign strobe.live  = run;
  assign strobe.legAb = run && (cnt < CNT_W'(HALF));
  assign strobe.legCd = run && (shifted < (CNT_W+1)'(HALF));
endmodule

// File: rtl/psb_dead_chan.sv
module psb_dead_chan #(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic              kill,
  input  logic [DEAD_W-1:0] deadSet,
  output logic              gateOut
);
  logic [DEAD_W-1:0] onCnt;

  // Counts cycles the raw request has been high; restarts on kill.
  always_ff @(posedge clk) begin
    if (!rstN || kill || !rawIn)
      onCnt <= '0;
    else if (onCnt != '1)
      onCnt <= onCnt + 1'b1;
  end

  assign gateOut = rawIn && !kill && (onCnt >= deadSet);
endmodule

// File: rtl/psb_datapath.sv
module psb_datapath
  import psb_pkg::*;
#(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  psbStrobe_t        strobe,
  input  logic [DEAD_W-1:0] deadAb,
  input  logic [DEAD_W-1:0] deadCd,
  input  logic              outDisable,
  output logic [3:0]        gate
);
  logic [3:0] raw;

  // Index 0..3 = A, B, C, D.
  assign raw[0] = strobe.live &&  strobe.legAb;
  assign raw[1] = strobe.live && !strobe.legAb;
  assign raw[2] = strobe.live &&  strobe.legCd;
  assign raw[3] = strobe.live && !strobe.legCd;

  for (genvar g = 0; g < 4; g++) begin : gChan
    logic [DEAD_W-1:0] deadSel;
    if (g < 2) begin : gLegAb
      assign deadSel = deadAb;
    end else begin : gLegCd
      assign deadSel = deadCd;
    end
    psb_dead_chan #(.DEAD_W(DEAD_W)) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (raw[g]),
      .kill    (outDisable),
      .deadSet (deadSel),
      .gateOut (gate[g])
    );
  end
endmodule

// File: rtl/psb_bridge.sv
module psb_bridge
  import psb_pkg::*;
#(
  parameter int PERIOD  = 20,
  parameter int CMD_W   = 8,
  parameter int ZERO_TH = 4,
  parameter int DEAD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodTick,
  input  logic [CMD_W-1:0]  phaseCmd,
  input  logic [DEAD_W-1:0] deadAbSet,
  input  logic [DEAD_W-1:0] deadCdSet,
  input  logic              outDisable,
  output logic              outA,
  output logic              outB,
  output logic              outC,
  output logic              outD
);
  psbStrobe_t        strobe;
  logic [DEAD_W-1:0] deadAb;
  logic [DEAD_W-1:0] deadCd;
  logic [3:0]        gate;

  psb_ctrl #(.PERIOD(PERIOD), .CMD_W(CMD_W), .ZERO_TH(ZERO_TH), .DEAD_W(DEAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodTick(periodTick), .phaseCmd(phaseCmd),
    .deadAbSet(deadAbSet), .deadCdSet(deadCdSet),
    .strobe(strobe), .deadAb(deadAb), .deadCd(deadCd)
  );

  psb_datapath #(.DEAD_W(DEAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .deadAb(deadAb), .deadCd(deadCd),
    .outDisable(outDisable), .gate(gate)
  );

  assign outA = gate[0];
  assign outB = gate[1];
  assign outC = gate[2];
  assign outD = gate[3];
endmodule

// File: rtl/psb_bridge_chk.sv
module psb_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic periodTick,
  input logic outDisable,
  input logic outA,
  input logic outB,
  input logic outC,
  input logic outD
);
  logic seenTick;
  always_ff @(posedge clk) begin
    if (!rstN) seenTick <= 1'b0;
    else if (periodTick) seenTick <= 1'b1;
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !seenTick |-> !(outA || outB || outC || outD));

  assert_ab_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB));

  assert_cd_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(outC && outD));

  assert_a_rise_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outA) |-> !$past(outB));

  assert_c_rise_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outC) |-> !$past(outD));

  assert_disable_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> !(outA || outB || outC || outD));
endmodule

bind psb_bridge psb_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .periodTick(periodTick), .outDisable(outDisable),
  .outA(outA), .outB(outB), .outC(outC), .outD(outD)
);

// File: tb/psb_bridge_tb.sv
module psb_bridge_tb;
  localparam int PERIOD  = 20;
  localparam int HALF    = PERIOD / 2;
  localparam int CMD_W   = 8;
  localparam int ZERO_TH = 4;
  localparam int DEAD_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodTick = 1'b0;
  logic [CMD_W-1:0] phaseCmd = '0;
  logic [DEAD_W-1:0] deadAbSet = '0;
  logic [DEAD_W-1:0] deadCdSet = '0;
  logic outDisable = 1'b0;
  logic outA, outB, outC, outD;

  always #4 clk = ~clk;

  psb_bridge #(.PERIOD(PERIOD), .CMD_W(CMD_W), .ZERO_TH(ZERO_TH), .DEAD_W(DEAD_W)) u_dut (
    .clk(clk), .rstN(rstN), .periodTick(periodTick), .phaseCmd(phaseCmd),
    .deadAbSet(deadAbSet), .deadCdSet(deadCdSet), .outDisable(outDisable),
    .outA(outA), .outB(outB), .outC(outC), .outD(outD)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mCnt = 0, mPh = 0, mDab = 1, mDcd = 1;
  bit mRun = 0;
  int mOn[4] = '{0, 0, 0, 0};

  function automatic int refPhase(int c);
    if (c <= ZERO_TH) return 0;
    if (c - ZERO_TH >= HALF) return HALF;
    return c - ZERO_TH;
  endfunction

  function automatic int refDead(int d);
    if (d < 1) return 1;
    if (d > HALF - 1) return HALF - 1;
    return d;
  endfunction

  function automatic bit refRaw(int i);
    int s;
    s = (mCnt - mPh + PERIOD) % PERIOD;
    case (i)
      0: return mRun && (mCnt < HALF);
      1: return mRun && !(mCnt < HALF);
      2: return mRun && (s < HALF);
      default: return mRun && !(s < HALF);
    endcase
  endfunction

  task automatic compare(bit ds);
    logic [3:0] exp, act;
    for (int i = 0; i < 4; i++)
      exp[3-i] = !ds && refRaw(i) && (mOn[i] >= ((i < 2) ? mDab : mDcd));
    act = {outA, outB, outC, outD};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t ABCD actual=%b expected=%b", curReq, $time, act, exp);
    end
  endtask

  task automatic step(bit tk, bit ds);
    bit r[4];
    periodTick = tk;
    outDisable = ds;
    for (int i = 0; i < 4; i++) r[i] = refRaw(i);
    for (int i = 0; i < 4; i++) begin
      if (ds || !r[i]) mOn[i] = 0;
      else if (mOn[i] < (1 << DEAD_W) - 1) mOn[i]++;
    end
    if (tk) begin
      mCnt = 0; mRun = 1;
      mPh  = refPhase(int'(phaseCmd));
      mDab = refDead(int'(deadAbSet));
      mDcd = refDead(int'(deadCdSet));
    end else if (mRun) begin
      mCnt = (mCnt + 1) % PERIOD;
    end
    @(posedge clk);
    @(negedge clk);
    compare(ds);
  endtask

  task automatic runPeriods(int n, int cmd, int dab, int dcd, string req);
    curReq = req;
    phaseCmd = CMD_W'(cmd);
    deadAbSet = DEAD_W'(dab);
    deadCdSet = DEAD_W'(dcd);
    for (int k = 0; k < n * PERIOD; k++) step(k % PERIOD == 0, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b0);                 // R1: in reset
    rstN = 1'b1;
    curReq = "R1";
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0);   // R1: no tick yet
    runPeriods(3, 2, 3, 3, "R5");                   // R5, R2, R3: zero shift
    runPeriods(3, ZERO_TH, 3, 3, "R5");             // R5: exactly at threshold
    runPeriods(3, ZERO_TH + 6, 2, 5, "R4");         // R4, R7: phase 6
    runPeriods(2, ZERO_TH + 3, 4, 1, "R7");         // R7: swapped dead lengths
    runPeriods(3, 200, 3, 3, "R6");                 // R6: saturate 180 deg
    runPeriods(2, ZERO_TH + HALF, 2, 2, "R6");      // R6: exactly half period
    runPeriods(3, ZERO_TH + 2, 0, 15, "R8");        // R8, R9: zero and oversize
    runPeriods(2, ZERO_TH + 5, 9, 12, "R9");        // R9: at and above limit
    // R11: change settings mid-period, take effect only at next tick
    curReq = "R11";
    phaseCmd = CMD_W'(ZERO_TH + 1); deadAbSet = 2; deadCdSet = 2;
    for (int k = 0; k < 3 * PERIOD; k++) begin
      if (k == PERIOD + 7) begin
        phaseCmd = CMD_W'(ZERO_TH + 8); deadAbSet = 7; deadCdSet = 1;
      end
      step(k % PERIOD == 0, 1'b0);
    end
    // R10: disable pulse inside first-leg high window, released while raw high
    curReq = "R10";
    phaseCmd = CMD_W'(ZERO_TH + 4); deadAbSet = 3; deadCdSet = 3;
    for (int k = 0; k < 3 * PERIOD; k++)
      step(k % PERIOD == 0, (k >= PERIOD + 4) && (k < PERIOD + 6));
    // R10: long disable spanning a tick
    for (int k = 0; k < 2 * PERIOD; k++)
      step(k % PERIOD == 0, (k >= 15) && (k < 27));
    runPeriods(1, ZERO_TH + 4, 3, 3, "R2");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule